// File: doc/BRIEF.md
# Up-Counting Interval Timer with Buffered Reload

This block is a small memory-mapped timer for periodic or single-shot interrupt generation. A prescaler divides the input clock by a programmable ratio to produce count ticks. An up-counter advances on each tick from zero to a programmable limit and then wraps back to zero. Each wrap raises an update event, which sets a sticky flag and can drive an interrupt line.

Software reaches the block through a single-cycle word bus. A write takes effect at the clock edge where the select is sampled, and read data is valid combinationally in the same cycle. The limit register can be written straight into the active comparison value. Optionally it can be buffered and transferred only at the next update event, so that a running period is never cut short. A one-pulse mode makes the timer halt itself after a single period. A software update strobe reloads the counter and the buffered prescaler and limit values at any time.

The counter width is a parameter, 16 or 32 bits. Bits of the limit register above that width read back as zero, so software can probe the width by writing all ones.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, and `irq_o` is low.
- R2: The prescaler register (byte offset 0x28, lower PSC_W bits kept) buffers a value P. The active divider changes to P only at an update event, and the counter then advances once every P+1 clocks.
- R3: When the run bit (control register at 0x00, bit 0) is set, the counter counts up from 0. The tick after it equals the active limit L is an overflow: the counter returns to 0, so a continuous period lasts (L+1)*(P+1) clocks.
- R4: Every update event sets the flag (status register at 0x10, bit 0). Writing 0 to that bit clears it, writing 1 leaves it unchanged, and a same-cycle update wins. `irq_o` is high exactly while the flag and the interrupt-enable bit (0x0C, bit 0) are both set.
- R5: Writing 1 to bit 0 of the event register (0x14) makes an update event. It zeroes the counter and the prescaler phase, loads the buffered divider and limit, and sets the flag. The event register always reads 0.
- R6: When the buffer bit (control bit 7) is 0, a write to the limit register (0x2C) changes the active limit at once. When it is 1, the active limit changes only at the next update event.
- R7: When the one-shot bit (control bit 3) is set, an overflow clears the run bit, so the timer stops after one period and control reads back with bit 0 clear.
- R8: Writing 0 to the control register halts counting. The count is held and resumes from the same value when the run bit is set again.
- R9: The limit register keeps CNT_W bits. Writing 0xFFFFFFFF reads back 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Update interrupt, level |

## Verification
The hardest situation to reach is a limit write that lands in the middle of a running period. Whether the period in flight uses the old limit or the new one depends only on the buffer bit. The bench enables the counter, then writes a new limit one edge later. It times the gap to the interrupt for both buffer settings, and a second gap shows that the buffered value reaches the next period. A halt partway through a period is handled the same way. The bench resumes the timer and compares the remaining time with the count that should have been held.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_IEN    = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_EVGEN  = 8'h14;
  localparam logic [7:0] OFS_PSC    = 8'h28;
  localparam logic [7:0] OFS_RELOAD = 8'h2C;

  localparam int BIT_RUN      = 0;
  localparam int BIT_ONESHOT  = 3;
  localparam int BIT_BUFFERED = 7;

  typedef struct packed {
    logic buffered;
    logic oneshot;
    logic run;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.run      = w[BIT_RUN];
    c.oneshot  = w[BIT_ONESHOT];
    c.buffered = w[BIT_BUFFERED];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_RUN]      = c.run;
    w[BIT_ONESHOT]  = c.oneshot;
    w[BIT_BUFFERED] = c.buffered;
    return w;
  endfunction

  // Overflow test: reached or passed the limit (a lowered limit still wraps)
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

  // Write-0-to-clear flag with set priority
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic wr, input logic wbit);
    if (set) return 1'b1;
    if (wr)  return cur & wbit;
    return cur;
  endfunction

endpackage

// File: rtl/rt_regs.sv
module rt_regs
  import reload_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              ovf_evt,
  input  logic              upd_evt,
  output ctrl_t             ctrl_q,
  output logic              uie_q,
  output logic              uif_q,
  output logic [PSC_W-1:0]  psc_buf_q,
  output logic [CNT_W-1:0]  arr_buf_q,
  output logic              ug_pulse,
  output logic              arr_now,
  output logic              ctrl_wr,
  output logic              stat_wr,
  output logic [31:0]       bus_rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_EVGEN  = ADDR_W'(OFS_EVGEN);
  localparam logic [ADDR_W-1:0] A_PSC    = ADDR_W'(OFS_PSC);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);

  logic wr;
  logic ien_wr, psc_wr, arr_wr, evg_wr;

  assign wr      = bus_sel && bus_we;
  assign ctrl_wr = wr && (bus_addr == A_CTRL);
  assign ien_wr  = wr && (bus_addr == A_IEN);
  assign stat_wr = wr && (bus_addr == A_STAT);
  assign evg_wr  = wr && (bus_addr == A_EVGEN);
  assign psc_wr  = wr && (bus_addr == A_PSC);
  assign arr_wr  = wr && (bus_addr == A_RELOAD);

  assign ug_pulse = evg_wr && bus_wdata[0];
  assign arr_now  = arr_wr && !ctrl_q.buffered;

  // Control: a software write wins over the one-shot self-stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_unpack(bus_wdata);
    end else if (ovf_evt && ctrl_q.oneshot) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uie_q     <= 1'b0;
      uif_q     <= 1'b0;
      psc_buf_q <= '0;
      arr_buf_q <= '0;
    end else begin
      if (ien_wr) uie_q <= bus_wdata[0];
      uif_q <= flag_next(uif_q, upd_evt, stat_wr, bus_wdata[0]);
      if (psc_wr) psc_buf_q <= bus_wdata[PSC_W-1:0];
      if (arr_wr) arr_buf_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        A_CTRL:   bus_rdata = ctrl_pack(ctrl_q);
        A_IEN:    bus_rdata = {31'b0, uie_q};
        A_STAT:   bus_rdata = {31'b0, uif_q};
        A_PSC:    bus_rdata = 32'(psc_buf_q);
        A_RELOAD: bus_rdata = 32'(arr_buf_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             upd_evt,
  input  logic [PSC_W-1:0] psc_buf,
  output logic             tick
);

  logic [PSC_W-1:0] psc_act_q;
  logic [PSC_W-1:0] phase_q;

  assign tick = run && (phase_q == psc_act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act_q <= '0;
      phase_q   <= '0;
    end else if (upd_evt) begin
      psc_act_q <= psc_buf;
      phase_q   <= '0;
    end else if (tick) begin
      phase_q   <= '0;
    end else if (run) begin
      phase_q   <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/rt_counter.sv
module rt_counter
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ug_pulse,
  input  logic             arr_now,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic [CNT_W-1:0] arr_buf,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] arr_act_q,
  output logic             ovf
);

  logic upd;

  assign ovf = tick && at_limit(32'(cnt_q), 32'(arr_act_q));
  assign upd = ovf || ug_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Direct write first; otherwise the buffered limit moves over at an update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_act_q <= '0;
    end else if (arr_now) begin
      arr_act_q <= arr_wdata;
    end else if (upd) begin
      arr_act_q <= arr_buf;
    end
  end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  ctrl_t            ctrl_w;
  logic             uie_w, uif_w;
  logic [PSC_W-1:0] psc_buf_w;
  logic [CNT_W-1:0] arr_buf_w, arr_act_w, cnt_w;
  logic             ug_w, arr_now_w, ctrl_wr_w, stat_wr_w;
  logic             tick_w, ovf_w, upd_w;
  logic             run_w, oneshot_w;

  assign upd_w     = ovf_w || ug_w;
  assign run_w     = ctrl_w.run;
  assign oneshot_w = ctrl_w.oneshot;

  rt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ovf_evt   (ovf_w),
    .upd_evt   (upd_w),
    .ctrl_q    (ctrl_w),
    .uie_q     (uie_w),
    .uif_q     (uif_w),
    .psc_buf_q (psc_buf_w),
    .arr_buf_q (arr_buf_w),
    .ug_pulse  (ug_w),
    .arr_now   (arr_now_w),
    .ctrl_wr   (ctrl_wr_w),
    .stat_wr   (stat_wr_w),
    .bus_rdata (bus_rdata)
  );

  rt_prescaler #(.PSC_W(PSC_W)) psc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .upd_evt (upd_w),
    .psc_buf (psc_buf_w),
    .tick    (tick_w)
  );

  rt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .ug_pulse  (ug_w),
    .arr_now   (arr_now_w),
    .arr_wdata (bus_wdata[CNT_W-1:0]),
    .arr_buf   (arr_buf_w),
    .cnt_q     (cnt_w),
    .arr_act_q (arr_act_w),
    .ovf       (ovf_w)
  );

  assign irq_o = uif_w && uie_w;

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ovf,
  input logic             ug,
  input logic             run,
  input logic             oneshot,
  input logic             ctrl_wr,
  input logic             stat_wr,
  input logic [CNT_W-1:0] cnt,
  input logic             uif,
  input logic             uie,
  input logic             irq
);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf && !ug) |=> (cnt == $past(cnt) + 1'b1));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || ug) |=> (cnt == '0));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || ug) |=> uif);

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && !ovf && !ug) |=> $stable(uif));

  p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !uie |-> !irq);

  p_ug_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (uif && cnt == '0));

  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && oneshot && !ctrl_wr) |=> !run);

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug) |=> $stable(cnt));

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_w),
  .ovf     (ovf_w),
  .ug      (ug_w),
  .run     (run_w),
  .oneshot (oneshot_w),
  .ctrl_wr (ctrl_wr_w),
  .stat_wr (stat_wr_w),
  .cnt     (cnt_w),
  .uif     (uif_w),
  .uie     (uie_w),
  .irq     (irq_o)
);

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int PSC_W  = 16;
  localparam int ADDR_W = 8;
  localparam int LIMIT  = 5000;

  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10,
                         A_EVG = 8'h14, A_PSC = 8'h28, A_ARR = 8'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  // Edges counted until irq_o is seen high
  task automatic wait_irq(output int j);
    j = 0;
    while (!irq_o && j < LIMIT) begin
      @(posedge clk);
      #1 j++;
    end
  endtask

  // Stop, load divider and limit through an update, clear flag, apply control
  task automatic setup(input int lim, input int psc, input logic [31:0] ctrl);
    wr(A_CTRL, 0);
    wr(A_PSC, psc);
    wr(A_ARR, lim);
    wr(A_EVG, 1);
    wr(A_STAT, 0);
    wr(A_CTRL, ctrl);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int j;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check(32'(irq_o), 0, "R1 irq");
    rd(A_CTRL, d); check(d, 0, "R1 ctrl");
    rd(A_IEN, d);  check(d, 0, "R1 ien");
    rd(A_STAT, d); check(d, 0, "R1 stat");
    rd(A_PSC, d);  check(d, 0, "R1 psc");
    rd(A_ARR, d);  check(d, 0, "R1 arr");

    // R9: limit width readback; R2 prescaler keeps PSC_W bits
    wr(A_ARR, 32'hFFFF_FFFF);
    rd(A_ARR, d); check(d, 32'((64'd1 << CNT_W) - 1), "R9 arr width");
    wr(A_PSC, 32'h0001_2345);
    rd(A_PSC, d); check(d, 32'h0001_2345 & 32'((64'd1 << PSC_W) - 1), "R2 psc width");

    // R5: event register reads zero, strobe sets the flag
    rd(A_EVG, d); check(d, 0, "R5 evgen read");
    wr(A_STAT, 0);
    wr(A_EVG, 1);
    rd(A_STAT, d); check(d, 1, "R5 strobe sets flag");

    wr(A_IEN, 1);

    // R3: sweep limit and divider, first and continuous periods
    for (int lim = 0; lim <= 4; lim++) begin
      for (int p = 0; p <= 3; p++) begin
        setup(lim, p, 32'h1);
        wait_irq(j);
        check(j, (lim + 1) * (p + 1), $sformatf("R3 first L=%0d P=%0d", lim, p));
        wr(A_STAT, 0);
        wait_irq(j);
        check(j, (lim + 1) * (p + 1) - 1, $sformatf("R3 cont L=%0d P=%0d", lim, p));
      end
    end

    // R2: written divider waits for an update
    wr(A_CTRL, 0);
    wr(A_PSC, 0);
    wr(A_ARR, 3);
    wr(A_EVG, 1);
    wr(A_PSC, 2);
    wr(A_STAT, 0);
    wr(A_CTRL, 1);
    wait_irq(j); check(j, 4, "R2 old divider");
    wr(A_EVG, 1);
    wr(A_STAT, 0);
    wait_irq(j); check(j, 11, "R2 divider after update");

    // R6: buffered limit write mid-period
    setup(2, 0, 32'h81);
    wr(A_ARR, 5);
    wait_irq(j); check(j, 2, "R6 buffered keeps old limit");
    wr(A_STAT, 0);
    wait_irq(j); check(j, 5, "R6 buffered limit next period");
    setup(2, 0, 32'h01);
    wr(A_ARR, 5);
    wait_irq(j); check(j, 5, "R6 direct limit");

    // R7: one-shot stops itself
    setup(2, 0, 32'h09);
    wait_irq(j); check(j, 3, "R7 one-shot period");
    rd(A_CTRL, d); check(d, 32'h08, "R7 run bit cleared");
    wr(A_STAT, 0);
    repeat (20) @(posedge clk);
    #1 check(32'(irq_o), 0, "R7 no second event");

    // R8: halt holds the count
    setup(9, 0, 32'h01);
    repeat (4) @(posedge clk);
    wr(A_CTRL, 0);
    repeat (30) @(posedge clk);
    #1 check(32'(irq_o), 0, "R8 halted");
    wr(A_CTRL, 1);
    wait_irq(j); check(j, 5, "R8 resume remaining");

    // R4: enable masking and write-0-to-clear
    wr(A_IEN, 0);
    setup(1, 0, 32'h01);
    repeat (10) @(posedge clk);
    #1 check(32'(irq_o), 0, "R4 masked irq");
    wr(A_CTRL, 0);
    wr(A_STAT, 1);
    rd(A_STAT, d); check(d, 1, "R4 write one keeps flag");
    wr(A_IEN, 1);
    #1 check(32'(irq_o), 1, "R4 irq when enabled");
    wr(A_STAT, 0);
    rd(A_STAT, d); check(d, 0, "R4 flag cleared");
    check(32'(irq_o), 0, "R4 irq low after clear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule